// File: doc/BRIEF.md
# Serial GPIO Shift Controller

This block drives a serial GPIO expander chain. Output pin values sit in a latch that is loaded through a small register port. Input pin values come back over the same chain. A programmable divider turns the system clock into a slow shift clock. In each frame the block shifts the output latch out one bit per shift-clock period and samples the returning serial input on every rising shift-clock edge. It then pulses a load strobe so that the external chain can capture the outputs and reload its inputs.

Three registers sit on the port. The value register returns the inputs captured in the last complete frame when read, and loads the output latch when written. A readback register returns the output latch. A control register holds the divider value, the number of pin groups of eight per frame, and the engine enable. All reads are combinational from the address. All writes take effect on the clock edge at which the write strobe is sampled.

Top module: `sgpio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the shift clock, serial output and load strobe are 0, and all three registers read 0.
- R2: While the engine runs, the shift clock toggles once every N+1 system cycles, so one period is 2×(N+1) cycles. N is the 16-bit divider field at control bits [31:16].
- R3: The control register (address 0x8) holds the enable at bit 0, the group count at bits [6 +: CNT_W] and the divider at bits [31:16]. It reads back exactly what was written, and every other bit reads as 0.
- R4: The serial output presents the output latch, least significant bit first. The latch is copied when a frame starts, the output moves to the next bit on each falling shift-clock edge, and the bit in force at the k-th rising edge of a frame is latch bit k-1.
- R5: A frame has 8×count rising shift-clock edges. On the falling edge that follows the last one, the load strobe is high for exactly one system cycle and the shift clock is low in that cycle.
- R6: Reading the value register (address 0x0) returns the inputs of the last complete frame. Bit i is the serial input sampled at the (i+1)-th rising edge of that frame, and bits at or above the frame length read 0.
- R7: Writing the value register sets the output latch from write-data bits [MAX_PINS-1:0]. The readback register (address 0x4) returns the latch from the next cycle on, with upper bits 0. The serial output uses the new latch only from the next frame start.
- R8: While the enable bit is 0, the shift clock stays low, no load strobe occurs, and the frame restarts from its first bit once the engine is enabled.
- R9: A group count above MAX_PINS/8 acts as MAX_PINS/8. A count of 0 keeps the engine idle, as in R8.
- R10: The value register changes only in the cycle in which the load strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register byte address (0x0 value, 0x4 readback, 0x8 control) |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ser_din | input | 1 | Serial input from the chain |
| ser_clk | output | 1 | Shift clock |
| ser_dout | output | 1 | Serial output to the chain |
| ser_load | output | 1 | One-cycle end-of-frame strobe |

## Verification
The bench builds the block with MAX_PINS = 16 and CNT_W = 3. A 3-bit count can then encode values up to 7, well beyond the two groups that fit, so the clamp of R9 is reached. Frames stay short (16 bits), so many complete frames run at several divider values, including N = 0 where the shift clock toggles every cycle. The outputs are compared against a behavioural model on every cycle, and directed checks measure the period, the number of edges between loads, and the bit order on the serial output.

// File: rtl/sgpio_pkg.sv
// Package: shared register addresses and control field positions for the
// serial GPIO controller. Assumes a 32-bit register data path.
package sgpio_pkg;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam int DIV_W    = 16;
    localparam int DIV_LSB  = 16;
    localparam int CNT_LSB  = 6;
    localparam int EN_BIT   = 0;

    localparam logic [ADDR_W-1:0] A_VALUE = 4'h0;
    localparam logic [ADDR_W-1:0] A_OUTRB = 4'h4;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'h8;
endpackage

// File: rtl/sgpio_regs.sv
// Module: register file. Holds the output latch and the control fields and
// forms the combinational read data. Assumes MAX_PINS <= 32 and
// CNT_LSB + CNT_W <= DIV_LSB.
module sgpio_regs
    import sgpio_pkg::*;
#(
    parameter int MAX_PINS = 32,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [MAX_PINS-1:0] in_word,
    output logic [DATA_W-1:0]   rdata,
    output logic [MAX_PINS-1:0] out_latch,
    output logic [DIV_W-1:0]    div_n,
    output logic [CNT_W-1:0]    grp_cnt,
    output logic                enable
);
    logic [DATA_W-1:0] in_ext;
    logic [DATA_W-1:0] out_ext;
    logic [DATA_W-1:0] ctrl_word;

    // Register writes: value address loads the latch, control address the fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_latch <= '0;
            div_n     <= '0;
            grp_cnt   <= '0;
            enable    <= 1'b0;
        end else if (we) begin
            if (addr == A_VALUE) begin
                out_latch <= wdata[MAX_PINS-1:0];
            end else if (addr == A_CTRL) begin
                div_n   <= wdata[DIV_LSB +: DIV_W];
                grp_cnt <= wdata[CNT_LSB +: CNT_W];
                enable  <= wdata[EN_BIT];
            end
        end
    end

    // Zero extension of the pin-wide words to the data path width.
    generate
        if (MAX_PINS < DATA_W) begin : g_ext
            assign in_ext  = {{(DATA_W-MAX_PINS){1'b0}}, in_word};
            assign out_ext = {{(DATA_W-MAX_PINS){1'b0}}, out_latch};
        end else begin : g_full
            assign in_ext  = in_word;
            assign out_ext = out_latch;
        end
    endgenerate

    // Control word assembly for readback.
    always_comb begin
        ctrl_word                    = '0;
        ctrl_word[DIV_LSB +: DIV_W]  = div_n;
        ctrl_word[CNT_LSB +: CNT_W]  = grp_cnt;
        ctrl_word[EN_BIT]            = enable;
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_VALUE: rdata = in_ext;
            A_OUTRB: rdata = out_ext;
            A_CTRL:  rdata = ctrl_word;
            default: rdata = '0;
        endcase
    end

    // R7: a write to the value address lands in the latch on the next cycle.
    a_r7_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_VALUE) |=> (out_latch == $past(wdata[MAX_PINS-1:0])));
endmodule

// File: rtl/sgpio_clkdiv.sv
// Module: shift-clock divider. A down-counter reloads from N and the shift
// clock toggles each time it reaches zero. Assumes run is registered upstream.
module sgpio_clkdiv
    import sgpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             sclk,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             tick;

    assign tick      = run && (cnt_q == '0);
    assign rise_tick = tick && !sclk;
    assign fall_tick = tick && sclk;

    // Divider counter and shift-clock toggle; idle holds the clock low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (!run) begin
            cnt_q <= div_n;
            sclk  <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q <= div_n;
            sclk  <= ~sclk;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R2: the clock holds while the counter has not reached zero.
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q != '0) |=> $stable(sclk));
    // R8: an idle engine brings the clock low.
    a_r8_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);
endmodule

// File: rtl/sgpio_shift.sv
// Module: frame engine. Shifts the latch out LSB first on falling ticks,
// samples the serial input on rising ticks, and at frame end copies the
// inputs and pulses the load strobe. Assumes nbits <= MAX_PINS and
// that nbits changes only while run is low.
module sgpio_shift #(
    parameter int MAX_PINS = 32,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                rise_tick,
    input  logic                fall_tick,
    input  logic                sclk,
    input  logic [IDX_W-1:0]    nbits,
    input  logic [MAX_PINS-1:0] out_latch,
    input  logic                din,
    output logic                dout,
    output logic                load,
    output logic [MAX_PINS-1:0] in_word
);
    logic [IDX_W-1:0]    idx_q;
    logic [MAX_PINS-1:0] sh_out;
    logic [MAX_PINS-1:0] sh_in;

    assign dout = sh_out[0];

    // Frame sequencing: sample, shift, and end-of-frame capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            sh_out  <= '0;
            sh_in   <= '0;
            in_word <= '0;
            load    <= 1'b0;
        end else begin
            load <= 1'b0;
            if (!run) begin
                idx_q  <= '0;
                sh_out <= out_latch;
                sh_in  <= '0;
            end else if (rise_tick) begin
                sh_in <= sh_in | (MAX_PINS'(din) << idx_q);
                idx_q <= idx_q + 1'b1;
            end else if (fall_tick) begin
                if (idx_q >= nbits) begin
                    load    <= 1'b1;
                    in_word <= sh_in;
                    sh_out  <= out_latch;
                    sh_in   <= '0;
                    idx_q   <= '0;
                end else begin
                    sh_out <= sh_out >> 1;
                end
            end
        end
    end

    // R10: the captured inputs change only together with the load strobe.
    a_r10_value_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (in_word != $past(in_word)) |-> load);
    // R5: the strobe lasts one cycle and comes with the clock low.
    a_r5_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
    a_r5_load_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !sclk);
    // R8: no strobe follows an idle cycle.
    a_r8_idle_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !load);
endmodule

// File: rtl/sgpio_ctrl.sv
// Module: top of the serial GPIO controller. Clamps the group count, decides
// whether the engine runs, and wires registers, divider and frame engine.
// Assumes MAX_PINS is a multiple of 8 and at most 32.
module sgpio_ctrl
    import sgpio_pkg::*;
#(
    parameter int MAX_PINS = 32,
    parameter int CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ser_din,
    output logic              ser_clk,
    output logic              ser_dout,
    output logic              ser_load
);
    localparam int IDX_W = $clog2(MAX_PINS + 1);
    localparam int RAW_W = CNT_W + 3;

    logic [MAX_PINS-1:0] out_latch;
    logic [MAX_PINS-1:0] in_word;
    logic [DIV_W-1:0]    div_n;
    logic [CNT_W-1:0]    grp_cnt;
    logic                enable;
    logic [RAW_W-1:0]    raw_bits;
    logic [IDX_W-1:0]    nbits;
    logic                run;
    logic                rise_tick;
    logic                fall_tick;

    assign raw_bits = {grp_cnt, 3'b000};

    // Frame length: count times eight, clamped to the pin capacity.
    always_comb begin
        if (raw_bits > RAW_W'(MAX_PINS)) nbits = IDX_W'(MAX_PINS);
        else                             nbits = IDX_W'(raw_bits);
    end

    assign run = enable && (nbits != '0);

    sgpio_regs #(.MAX_PINS(MAX_PINS), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
        .wdata(reg_wdata), .in_word(in_word), .rdata(reg_rdata),
        .out_latch(out_latch), .div_n(div_n), .grp_cnt(grp_cnt),
        .enable(enable)
    );

    sgpio_clkdiv u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div_n(div_n),
        .sclk(ser_clk), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    sgpio_shift #(.MAX_PINS(MAX_PINS), .IDX_W(IDX_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .run(run), .rise_tick(rise_tick),
        .fall_tick(fall_tick), .sclk(ser_clk), .nbits(nbits),
        .out_latch(out_latch), .din(ser_din), .dout(ser_dout),
        .load(ser_load), .in_word(in_word)
    );

    // R9: a zero count keeps the shift clock low.
    a_r9_zero_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_cnt == '0) |=> !ser_clk);
endmodule

// File: tb/sim_sgpio_ctrl.sv
module sim_sgpio_ctrl;
    localparam int P  = 16;
    localparam int CW = 3;
    localparam int MAXB = P / 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ser_din = 1'b0;
    logic        ser_clk, ser_dout, ser_load;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sgpio_ctrl #(.MAX_PINS(P), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_din(ser_din),
        .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_load(ser_load)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, stepped on each rising clock edge.
    int          m_div, m_idx;
    logic        m_sclk, m_load, m_en, started = 1'b0;
    logic [P-1:0] m_shout, m_shin, m_inw, m_latch;
    logic [15:0] m_divn;
    logic [CW-1:0] m_cnt;

    always @(posedge clk) begin
        int nb;
        logic run;
        started <= 1'b1;
        if (!rst_n) begin
            m_div = 0; m_idx = 0; m_sclk = 0; m_load = 0; m_en = 0;
            m_shout = '0; m_shin = '0; m_inw = '0; m_latch = '0;
            m_divn = '0; m_cnt = '0;
        end else begin
            nb  = (int'(m_cnt) > MAXB) ? P : int'(m_cnt) * 8;
            run = m_en && (nb != 0);
            m_load = 0;
            if (!run) begin
                m_div = int'(m_divn); m_sclk = 0; m_idx = 0;
                m_shout = m_latch; m_shin = '0;
            end else if (m_div != 0) begin
                m_div--;
            end else begin
                m_div = int'(m_divn);
                if (!m_sclk) begin
                    m_shin[m_idx] = ser_din;
                    m_idx++;
                end else if (m_idx >= nb) begin
                    m_load = 1; m_inw = m_shin; m_shout = m_latch;
                    m_idx = 0; m_shin = '0;
                end else begin
                    m_shout = m_shout >> 1;
                end
                m_sclk = !m_sclk;
            end
            if (reg_we && reg_addr == 4'h0) m_latch = reg_wdata[P-1:0];
            if (reg_we && reg_addr == 4'h8) begin
                m_divn = reg_wdata[31:16];
                m_cnt  = reg_wdata[6 +: CW];
                m_en   = reg_wdata[0];
            end
        end
    end

    function automatic logic [31:0] exp_rdata(input logic [3:0] a);
        logic [31:0] c;
        c = '0;
        case (a)
            4'h0: c[P-1:0] = m_inw;
            4'h4: c[P-1:0] = m_latch;
            4'h8: begin c[31:16] = m_divn; c[6 +: CW] = m_cnt; c[0] = m_en; end
            default: c = '0;
        endcase
        return c;
    endfunction

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R2 shift clock", {31'b0, ser_clk}, {31'b0, m_sclk});
            chk("R4 serial out", {31'b0, ser_dout}, {31'b0, m_shout[0]});
            chk("R5 load strobe", {31'b0, ser_load}, {31'b0, m_load});
            case (reg_addr)
                4'h0: chk("R6 value read", reg_rdata, exp_rdata(reg_addr));
                4'h4: chk("R7 readback", reg_rdata, exp_rdata(reg_addr));
                default: chk("R3 control read", reg_rdata, exp_rdata(reg_addr));
            endcase
        end
    end

    // Serial input stimulus from a bench LFSR.
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ser_din = lfsr[0];
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); #1;
        reg_we = 1'b0; reg_addr = 4'h0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        #1 reg_addr = 4'h0;
    endtask

    function automatic logic [31:0] ctrl(input int n, input int cnt, input bit en);
        logic [31:0] c;
        c = '0;
        c[31:16] = 16'(n);
        c[6 +: CW] = CW'(cnt);
        c[0] = en;
        return c;
    endfunction

    task automatic wait_rise();
        logic p;
        p = ser_clk;
        forever begin
            @(negedge clk);
            if (ser_clk && !p) break;
            p = ser_clk;
        end
    endtask

    task automatic wait_load();
        do @(negedge clk); while (!ser_load);
    endtask

    task automatic period(output int n);
        logic p;
        wait_rise();
        n = 0; p = 1'b1;
        forever begin
            @(negedge clk);
            n++;
            if (ser_clk && !p) break;
            p = ser_clk;
        end
    endtask

    task automatic rises_per_frame(output int r);
        logic p;
        wait_load();
        r = 0; p = ser_clk;
        forever begin
            @(negedge clk);
            if (ser_load) break;
            if (ser_clk && !p) r++;
            p = ser_clk;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        int lat;
        logic p;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports and in every register.
        chk("R1 clock", {31'b0, ser_clk}, 32'h0);
        chk("R1 dout", {31'b0, ser_dout}, 32'h0);
        chk("R1 load", {31'b0, ser_load}, 32'h0);
        rd(4'h0, d); chk("R1 value", d, 32'h0);
        rd(4'h4, d); chk("R1 readback", d, 32'h0);
        rd(4'h8, d); chk("R1 control", d, 32'h0);

        // R3: control field placement and readback.
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h8, d); chk("R3 control mask", d, 32'hFFFF_01C1);
        wr(4'h8, ctrl(0, 2, 0));

        // R7: latch write, readback, upper bits dropped.
        wr(4'h0, 32'hFFFF_A5C3);
        rd(4'h4, d); chk("R7 readback value", d, 32'h0000_A5C3);

        // R8: enable low keeps everything idle.
        repeat (40) begin
            @(negedge clk);
            chk("R8 idle clock", {31'b0, ser_clk}, 32'h0);
            chk("R8 idle load", {31'b0, ser_load}, 32'h0);
        end

        // R2: period at several divider values.
        wr(4'h8, ctrl(0, 2, 1));
        period(n); chk("R2 period N=0", n, 2);
        wr(4'h8, ctrl(1, 2, 1));
        period(n); chk("R2 period N=1", n, 4);
        wr(4'h8, ctrl(3, 2, 1));
        period(n); chk("R2 period N=3", n, 8);

        // R5: edges per frame; R9: clamp of an oversized count.
        rises_per_frame(n); chk("R5 rises per frame cnt=2", n, 16);
        wr(4'h8, ctrl(1, 0, 0));
        wr(4'h8, ctrl(1, 1, 1));
        rises_per_frame(n); chk("R5 rises per frame cnt=1", n, 8);
        wr(4'h8, ctrl(1, 0, 0));
        wr(4'h8, ctrl(1, 7, 1));
        rises_per_frame(n); chk("R9 clamped rises", n, 16);

        // R4: bit order on the serial output for a latch loaded before a frame.
        wr(4'h0, 32'h0000_3C96);
        lat = 32'h3C96;
        wait_load();
        p = ser_clk;
        for (int k = 0; k < 16; k++) begin
            forever begin
                @(negedge clk);
                if (ser_clk && !p) break;
                p = ser_clk;
            end
            p = ser_clk;
            chk("R4 bit order", {31'b0, ser_dout}, {31'b0, lat[k]});
        end

        // R7: a mid-frame write shows in readback but not on the current frame.
        wr(4'h0, 32'h0000_0001);
        rd(4'h4, d); chk("R7 mid-frame readback", d, 32'h1);
        wait_load(); wait_load();

        // R6 / R10: captured inputs after a frame, held between strobes.
        rd(4'h0, d); chk("R6 captured inputs", d, {16'h0, m_inw});
        wr(4'h8, ctrl(0, 1, 1));
        wait_load(); wait_load();
        rd(4'h0, d); chk("R6 short frame upper zero", d & 32'hFFFF_FF00, 32'h0);

        // R9: count of zero with enable set stays idle.
        wr(4'h8, ctrl(0, 0, 1));
        repeat (30) begin
            @(negedge clk);
            chk("R9 zero count clock", {31'b0, ser_clk}, 32'h0);
            chk("R10 no load when idle", {31'b0, ser_load}, 32'h0);
        end

        // R8: re-enable restarts from the first bit.
        wr(4'h8, ctrl(2, 2, 1));
        rises_per_frame(n); chk("R8 restart frame length", n, 16);
        wr(4'h8, ctrl(0, 0, 0));
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule